// File: doc/BRIEF.md
# Atomic-Event Memory Ordering Gate

This block stands between a core's queue of memory references and the port through which references leave the core. The queue presents its oldest pending reference at the head, one per cycle. For each one the gate decides in the same cycle whether the reference may be taken. A reference passes at once, waits for older traffic to drain, or is held in a small line buffer. References are presented in age order, so position in the stream gives relative age. A running count of outstanding references covers the ones that have gone out without an acknowledge from the cache and TLB side. That count is the only record the gate needs of older traffic.

Ordering is set by two things: whether an atomic event is open, and the address region of the reference. An event opens when a load-locked reference goes out. The gate fences the event at both ends without any barrier instruction. The load-locked reference waits until nothing older is outstanding. Inside the event every reference that leaves the core goes one at a time. Cacheable stores inside the event do not leave the core. The gate records their line addresses, up to a parameter number of distinct lines. When the closing store-conditional goes out, all recorded lines commit in that same cycle. Nothing younger leaves until the store-conditional has been acknowledged.

Outside an event, cacheable and ROM traffic flows without order. MMIO references wait for older traffic to drain. Configuration-header references are fenced on both sides.

Top module: `atomic_order_gate`

## Requirements
- R1: After reset the outstanding count is zero, no event is open (atom_active low), commit_valid and overflow_err are low, and a cacheable load presented in the first cycle after reset is taken and issued in that same cycle.
- R2: Outside an event, a cacheable (region 0) reference of kind load (0) or store (1) is taken and issued in the cycle it is presented, whatever the outstanding count, provided the count is below MAX_OUT and no fence hold is pending.
- R3: A load-locked reference (kind 2) is issued only in a cycle where the outstanding count is zero. atom_active rises in the cycle after it issues.
- R4: While atom_active is high, any reference that is issued and is not in the ROM region is issued only when the outstanding count is zero.
- R5: While atom_active is high, a cacheable store is taken with ref_issue low and its line is recorded in the buffer. A store to a line already recorded uses no new slot. Slots fill from bit 0 upward in order of first arrival.
- R6: A store-conditional (kind 3) inside an event issues only at zero outstanding. In that cycle commit_valid is high, commit_mask has one bit set per recorded line, and slot i of commit_lines holds the i-th recorded line. atom_active is low from the next cycle and the buffer is empty.
- R7: In the cycle after a store-conditional issues, no reference issues. Issue resumes only once the outstanding count is back to zero.
- R8: An MMIO reference (region 1) issues only at zero outstanding. A younger cacheable reference after it is not held and issues at once.
- R9: A configuration-header reference (region 2) issues only at zero outstanding. No reference issues until the count has again reached zero.
- R10: A ROM reference (region 3) is never delayed by a nonzero outstanding count, even inside an event, unless the count is at MAX_OUT or a fence hold is pending.
- R11: Each issue raises the outstanding count by one and each mem_ack lowers it by one. An ack at zero is ignored. At MAX_OUT nothing issues until an ack arrives.
- R12: A cacheable store inside an event whose line is new while all LINES slots are full is taken. In that cycle overflow_err pulses high, the event is aborted (atom_active low next cycle) and the buffer is cleared without a commit.
- R13: A store-conditional presented outside an event is fenced like one inside, but commit_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A reference is at the queue head |
| ref_kind | input | 2 | 0 load, 1 store, 2 load-locked, 3 store-conditional |
| ref_region | input | 2 | 0 cacheable, 1 MMIO, 2 configuration header, 3 ROM |
| ref_line | input | LINE_W | Cache-line address of the reference |
| ref_take | output | 1 | Head reference is consumed this cycle |
| ref_issue | output | 1 | Head reference leaves the core this cycle |
| mem_ack | input | 1 | One outstanding reference has been accepted by L1/TLB |
| commit_valid | output | 1 | Buffered event lines become visible this cycle |
| commit_mask | output | LINES | Slots holding a recorded line |
| commit_lines | output | LINES*LINE_W | Recorded line addresses, slot 0 in the low bits |
| atom_active | output | 1 | An atomic event is open |
| overflow_err | output | 1 | Pulse: event aborted on line-buffer overflow |

## Verification
Cacheable bursts with no acknowledges show that unordered traffic is never held back. The same burst driven into a full count shows that the credit limit works apart from region ordering. MMIO, configuration and ROM references are presented while older loads are still outstanding. This separates a fence before the reference, a fence on both sides, and no fence. A full event shows the drain in front of the load-locked reference and the one-at-a-time rule inside. Repeated and new store lines inside the event, with an interleaved ROM load, check merging and the commit in the store-conditional's own cycle. A five-line event and a stray store-conditional tell abort apart from commit.

// File: rtl/aog_pkg.sv
package aog_pkg;

   typedef enum logic [1:0] {
      K_LOAD  = 2'd0,
      K_STORE = 2'd1,
      K_LL    = 2'd2,
      K_SC    = 2'd3
   } ref_kind_e;

   typedef enum logic [1:0] {
      RG_CACHE = 2'd0,
      RG_MMIO  = 2'd1,
      RG_CFG   = 2'd2,
      RG_ROM   = 2'd3
   } region_e;

endpackage

// File: rtl/aog_credit_ctr.sv
module aog_credit_ctr #(
   parameter int MAX_OUT = 8,
   parameter int CW      = $clog2(MAX_OUT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);

   if (MAX_OUT < 1) begin : g_bad_max
      $error("aog_credit_ctr: MAX_OUT must be at least 1");
   end

   logic dec_ok;

   // an acknowledge with nothing outstanding is dropped
   assign dec_ok = dec && (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= count + CW'(inc) - CW'(dec_ok);
      end
   end

   assign empty = (count == '0);
   assign full  = (count >= CW'(MAX_OUT));

endmodule

// File: rtl/aog_line_buf.sv
module aog_line_buf #(
   parameter int LINES  = 4,
   parameter int LINE_W = 26,
   parameter bit MERGE  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_req,
   input  logic [LINE_W-1:0]      wr_line,
   input  logic                   clear,
   output logic                   hit,
   output logic                   full,
   output logic [LINES-1:0]       mask,
   output logic [LINES*LINE_W-1:0] lines
);

   localparam int SW = (LINES > 1) ? $clog2(LINES) : 1;

   if (LINES < 1) begin : g_bad_lines
      $error("aog_line_buf: LINES must be at least 1");
   end
   if (LINE_W < 1) begin : g_bad_width
      $error("aog_line_buf: LINE_W must be at least 1");
   end

   logic [LINES-1:0]             vld;
   logic [LINES-1:0][LINE_W-1:0] ent;
   logic [SW-1:0]                sel;
   logic                         found;

   // lowest free slot; slots fill in order because clearing is all-at-once
   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         if (!vld[i] && !found) begin
            sel   = SW'(i);
            found = 1'b1;
         end
      end
   end

   if (MERGE) begin : g_merge
      logic [LINES-1:0] match;
      for (genvar i = 0; i < LINES; i++) begin : g_cmp
         assign match[i] = vld[i] && (ent[i] == wr_line);
      end
      assign hit = |match;
   end else begin : g_nomerge
      assign hit = 1'b0;
   end

   assign full = &vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
         ent <= '0;
      end else if (clear) begin
         vld <= '0;
      end else if (wr_req && !hit && !full) begin
         vld[sel] <= 1'b1;
         ent[sel] <= wr_line;
      end
   end

   assign mask  = vld;
   assign lines = ent;

endmodule

// File: rtl/aog_policy.sv
module aog_policy
   import aog_pkg::*;
(
   input  logic       valid,
   input  logic [1:0] kind,
   input  logic [1:0] region,
   input  logic       in_event,
   input  logic       hold,
   input  logic       cnt_zero,
   input  logic       cnt_full,
   input  logic       buf_full,
   input  logic       buf_hit,
   output logic       take,
   output logic       issue,
   output logic       buffered,
   output logic       commit,
   output logic       overflow
);

   ref_kind_e k;
   region_e   rg;
   logic      need_drain;

   assign k  = ref_kind_e'(kind);
   assign rg = region_e'(region);

   // cacheable stores inside an event stay in the core until the SC
   assign buffered = in_event && (k == K_STORE) && (rg == RG_CACHE);

   always_comb begin
      need_drain = hold;
      case (rg)
         RG_MMIO, RG_CFG: need_drain = 1'b1;
         RG_ROM:          ;
         default:         if (in_event) need_drain = 1'b1;
      endcase
      if (k == K_LL || k == K_SC) need_drain = 1'b1;
   end

   assign take     = valid && (buffered || (!cnt_full && (!need_drain || cnt_zero)));
   assign issue    = take && !buffered;
   assign overflow = take && buffered && !buf_hit && buf_full;
   assign commit   = issue && (k == K_SC) && in_event;

endmodule

// File: rtl/atomic_order_gate.sv
module atomic_order_gate
   import aog_pkg::*;
#(
   parameter int LINES   = 4,
   parameter int LINE_W  = 26,
   parameter int MAX_OUT = 8,
   parameter bit MERGE   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ref_valid,
   input  logic [1:0]              ref_kind,
   input  logic [1:0]              ref_region,
   input  logic [LINE_W-1:0]       ref_line,
   output logic                    ref_take,
   output logic                    ref_issue,
   input  logic                    mem_ack,
   output logic                    commit_valid,
   output logic [LINES-1:0]        commit_mask,
   output logic [LINES*LINE_W-1:0] commit_lines,
   output logic                    atom_active,
   output logic                    overflow_err
);

   localparam int CNT_W = $clog2(MAX_OUT + 1);

   logic [CNT_W-1:0] out_cnt;
   logic             cnt_zero, cnt_full;
   logic             buf_hit, buf_full;
   logic             buffered, commit, overflow;
   logic             in_event, hold;

   aog_credit_ctr #(
      .MAX_OUT (MAX_OUT),
      .CW      (CNT_W)
   ) u_credit (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ref_issue),
      .dec   (mem_ack),
      .count (out_cnt),
      .empty (cnt_zero),
      .full  (cnt_full)
   );

   aog_policy u_policy (
      .valid    (ref_valid),
      .kind     (ref_kind),
      .region   (ref_region),
      .in_event (in_event),
      .hold     (hold),
      .cnt_zero (cnt_zero),
      .cnt_full (cnt_full),
      .buf_full (buf_full),
      .buf_hit  (buf_hit),
      .take     (ref_take),
      .issue    (ref_issue),
      .buffered (buffered),
      .commit   (commit),
      .overflow (overflow)
   );

   aog_line_buf #(
      .LINES  (LINES),
      .LINE_W (LINE_W),
      .MERGE  (MERGE)
   ) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (ref_take && buffered),
      .wr_line (ref_line),
      .clear   (commit || overflow),
      .hit     (buf_hit),
      .full    (buf_full),
      .mask    (commit_mask),
      .lines   (commit_lines)
   );

   // event state: opened by an issued LL, closed by commit or abort
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_event <= 1'b0;
      end else if (commit || overflow) begin
         in_event <= 1'b0;
      end else if (ref_issue && ref_kind_e'(ref_kind) == K_LL) begin
         in_event <= 1'b1;
      end
   end

   // trailing fence after SC and configuration-header accesses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= 1'b0;
      end else if (ref_issue) begin
         hold <= (ref_kind_e'(ref_kind) == K_SC) || (region_e'(ref_region) == RG_CFG);
      end
   end

   assign commit_valid = commit;
   assign atom_active  = in_event;
   assign overflow_err = overflow;

endmodule

// File: rtl/atomic_order_gate_chk.sv
module atomic_order_gate_chk #(
   parameter int MAX_OUT = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [1:0]                     ref_kind,
   input logic [1:0]                     ref_region,
   input logic                           ref_take,
   input logic                           ref_issue,
   input logic                           commit_valid,
   input logic                           atom_active,
   input logic                           overflow_err,
   input logic [$clog2(MAX_OUT+1)-1:0]   out_cnt
);

   // R3
   ll_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_issue && ref_kind == 2'd2) |-> (out_cnt == '0));

   // R4
   event_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_issue && atom_active && ref_region != 2'd3) |-> (out_cnt == '0));

   // R5
   buffer_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_take && !ref_issue) |-> atom_active);

   // R6
   commit_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> (ref_issue && ref_kind == 2'd3));

   // R6
   commit_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> !atom_active);

   // R7
   sc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_issue && ref_kind == 2'd3) |=> !ref_issue);

   // R8
   mmio_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_issue && ref_region == 2'd1) |-> (out_cnt == '0));

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_issue && ref_region == 2'd2) |=> !ref_issue);

   // R11
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cnt <= MAX_OUT));

   // R12
   overflow_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_err |=> !atom_active);

endmodule

bind atomic_order_gate atomic_order_gate_chk #(.MAX_OUT(MAX_OUT)) u_chk (.*);

// File: tb/atomic_order_gate_bench.sv
module atomic_order_gate_bench;

   localparam int LW = 8;
   localparam int NL = 4;
   localparam int MO = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              ref_valid;
   logic [1:0]        ref_kind;
   logic [1:0]        ref_region;
   logic [LW-1:0]     ref_line;
   logic              ref_take, ref_issue, mem_ack;
   logic              commit_valid, atom_active, overflow_err;
   logic [NL-1:0]     commit_mask;
   logic [NL*LW-1:0]  commit_lines;

   always #5 clk = ~clk;

   atomic_order_gate #(
      .LINES   (NL),
      .LINE_W  (LW),
      .MAX_OUT (MO),
      .MERGE   (1'b1)
   ) u_atomic_order_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_valid    (ref_valid),
      .ref_kind     (ref_kind),
      .ref_region   (ref_region),
      .ref_line     (ref_line),
      .ref_take     (ref_take),
      .ref_issue    (ref_issue),
      .mem_ack      (mem_ack),
      .commit_valid (commit_valid),
      .commit_mask  (commit_mask),
      .commit_lines (commit_lines),
      .atom_active  (atom_active),
      .overflow_err (overflow_err)
   );

   int errs   = 0;
   int checks = 0;

   // behavioural reference state
   int m_cnt  = 0;
   bit m_inev = 0;
   bit m_hold = 0;
   int m_buf[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one clock: compare before the edge, then advance the model
   task automatic step(input string req, output bit took);
      bit buffered, needz, hitl, e_take, e_issue, e_ovf, e_commit;
      int emask;
      #4;
      buffered = m_inev && ref_kind == 2'd1 && ref_region == 2'd0;
      needz = m_hold || ref_region == 2'd1 || ref_region == 2'd2 ||
              ref_kind == 2'd2 || ref_kind == 2'd3 ||
              (m_inev && ref_region != 2'd3);
      hitl = 0;
      foreach (m_buf[i]) if (m_buf[i] == int'(ref_line)) hitl = 1;
      e_take   = ref_valid && (buffered || (m_cnt < MO && (!needz || m_cnt == 0)));
      e_issue  = e_take && !buffered;
      e_ovf    = e_take && buffered && !hitl && m_buf.size() == NL;
      e_commit = e_issue && ref_kind == 2'd3 && m_inev;
      chk(ref_take == e_take, req, "ref_take", ref_take, e_take);
      chk(ref_issue == e_issue, req, "ref_issue", ref_issue, e_issue);
      chk(commit_valid == e_commit, req, "commit_valid", commit_valid, e_commit);
      chk(overflow_err == e_ovf, req, "overflow_err", overflow_err, e_ovf);
      chk(atom_active == m_inev, req, "atom_active", atom_active, m_inev);
      if (e_commit) begin
         emask = (1 << m_buf.size()) - 1;
         chk(int'(commit_mask) == emask, req, "commit_mask", commit_mask, emask);
         foreach (m_buf[i])
            chk(int'(commit_lines[i*LW +: LW]) == m_buf[i], req, "commit_line",
                commit_lines[i*LW +: LW], m_buf[i]);
      end
      took = e_take;
      @(posedge clk);
      m_cnt = m_cnt + (e_issue ? 1 : 0) - ((mem_ack && m_cnt > 0) ? 1 : 0);
      if (e_issue) m_hold = (ref_kind == 2'd3) || (ref_region == 2'd2);
      if (e_commit || e_ovf) begin
         m_inev = 0;
         m_buf.delete();
      end else begin
         if (e_issue && ref_kind == 2'd2) m_inev = 1;
         if (e_take && buffered && !hitl) m_buf.push_back(int'(ref_line));
      end
      @(negedge clk);
   endtask

   task automatic send(input int k, input int rg, input int ln, input bit ackw,
                       input string req);
      bit t = 0;
      ref_valid  = 1'b1;
      ref_kind   = 2'(k);
      ref_region = 2'(rg);
      ref_line   = LW'(ln);
      mem_ack    = ackw;
      for (int i = 0; i < 40; i++) begin
         step(req, t);
         if (t) break;
      end
      if (!t) chk(1'b0, req, "reference never taken", 0, 1);
      ref_valid = 1'b0;
      mem_ack   = 1'b0;
   endtask

   task automatic idle(input int n, input bit ack, input string req);
      bit t;
      ref_valid = 1'b0;
      mem_ack   = ack;
      for (int i = 0; i < n; i++) step(req, t);
      mem_ack = 1'b0;
   endtask

   initial begin
      #1_000_000;
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ref_valid = 1'b0; ref_kind = '0; ref_region = '0;
      ref_line = '0; mem_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and immediate cacheable load
      idle(1, 1'b0, "R1");
      send(0, 0, 8'h01, 1'b0, "R1");
      idle(2, 1'b1, "R1");

      // R2: unordered cacheable burst with no acknowledges
      send(0, 0, 8'h02, 1'b0, "R2");
      send(1, 0, 8'h03, 1'b0, "R2");
      send(0, 0, 8'h04, 1'b0, "R2");
      // R11: fill to MAX_OUT, then blocked until an ack
      send(1, 0, 8'h05, 1'b0, "R11");
      send(0, 0, 8'h06, 1'b1, "R11");
      idle(6, 1'b1, "R11");

      // R8: MMIO waits for older loads, younger load flows
      send(0, 0, 8'h10, 1'b0, "R8");
      send(0, 0, 8'h11, 1'b0, "R8");
      send(0, 1, 8'h12, 1'b1, "R8");
      send(0, 0, 8'h13, 1'b0, "R8");
      idle(4, 1'b1, "R8");

      // R9: configuration access fenced on both sides
      send(0, 0, 8'h20, 1'b0, "R9");
      send(1, 2, 8'h21, 1'b1, "R9");
      send(0, 0, 8'h22, 1'b1, "R9");
      idle(3, 1'b1, "R9");

      // R10: ROM ignores older outstanding traffic
      send(0, 0, 8'h30, 1'b0, "R10");
      send(0, 3, 8'h31, 1'b0, "R10");
      idle(4, 1'b1, "R10");

      // R3: LL drains older loads
      send(0, 0, 8'h40, 1'b0, "R3");
      send(0, 0, 8'h41, 1'b0, "R3");
      send(2, 0, 8'h42, 1'b1, "R3");
      // R4: serial inside the event
      send(0, 0, 8'h43, 1'b1, "R4");
      // R5: buffered stores, one merged
      send(1, 0, 8'h51, 1'b0, "R5");
      send(1, 0, 8'h51, 1'b0, "R5");
      send(1, 0, 8'h52, 1'b0, "R5");
      // R10: ROM inside the event while a load is outstanding
      send(0, 3, 8'h53, 1'b0, "R10");
      // R6: SC commits both lines
      send(3, 0, 8'h54, 1'b1, "R6");
      // R7: younger load held until SC acknowledged
      send(0, 0, 8'h55, 1'b1, "R7");
      idle(3, 1'b1, "R7");

      // R12: fifth distinct line aborts the event
      send(2, 0, 8'h60, 1'b1, "R12");
      send(1, 0, 8'h61, 1'b0, "R12");
      send(1, 0, 8'h62, 1'b0, "R12");
      send(1, 0, 8'h63, 1'b0, "R12");
      send(1, 0, 8'h64, 1'b0, "R12");
      send(1, 0, 8'h65, 1'b0, "R12");
      idle(1, 1'b0, "R12");
      // R13: stray SC is fenced but commits nothing
      send(3, 0, 8'h66, 1'b1, "R13");
      send(0, 0, 8'h67, 1'b1, "R13");
      idle(3, 1'b1, "R13");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule